// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs accesses to an external asynchronous memory over a 16-bit bus that carries both address and data. It takes one request at a time from an internal request interface: an address, a direction, write data and a width select (byte or halfword bus). It then drives an address latch enable, an active-low read strobe or an active-low write strobe, and the output enables of the shared pins. On a read it also captures the data that the memory returns.

The external latch holds the upper part of the address. The block keeps a copy of the value last placed in that latch. When a new request would load the same value, the latch phase is skipped and the access goes straight to the strobe. In byte mode a 24-bit address is split across the bus: the upper 16 bits go out during the latch phase, and the low 8 bits go out on the upper byte lane while the strobe is low. In halfword mode the latch phase carries a 16-bit address, and the whole bus then carries data. The latch pulse width, the strobe low time and the hold time each come from a cycle count on a configuration input.

Top module: `admux_bus_master`

## Requirements
- R1: While reset is held and right after it, rd_n and wr_n are high, ale is low, ad_oe is 00, done is low and rdata is zero. req_ready is high when enable is high.
- R2: The first access after reset or after enable rises has a latch phase. During that phase ale stays high for max(cfg_ale_cycles,1) cycles, both lanes are driven (ad_oe = 11) and neither strobe is low.
- R3: The latch value is req_addr[23:8] in byte mode and req_addr[15:0] in halfword mode. A latch phase runs only when this value differs from the one loaded last, or when no value has been loaded since reset or enable. Otherwise the strobe phase follows at once.
- R4: In byte mode (req_wide=0), ad_out carries addr[23:8] in the latch phase. While the strobe is low, ad_out[15:8] carries addr[7:0] and AD7-0 carry the data byte.
- R5: In halfword mode (req_wide=1), ad_out carries addr[15:0] in the latch phase. While the strobe is low, all 16 bits carry data.
- R6: For a write, wr_n is low for max(cfg_strobe_cycles,1) cycles. The write data stays on ad_out with ad_oe = 11 across the rising edge of wr_n and into the hold phase. rd_n and wr_n are never low together.
- R7: For a read, rd_n is low for max(cfg_strobe_cycles,1) cycles. The data lanes are released (ad_oe bit 0 for AD7-0, bit 1 for AD15-8) in the cycle before rd_n falls and while it is low. rdata takes ad_in on the rising edge of rd_n. In byte mode this is the low byte zero-extended.
- R8: done is a one-cycle pulse in the cycle that follows the rising edge of the strobe. For a read, rdata is valid in that same cycle.
- R9: After a read, at least one cycle with ad_oe = 00 comes before the bus is driven on AD7-0 again.
- R10: While enable is low, req_ready is low, requests are ignored and the strobes and ale stay inactive. Lowering enable forgets the loaded latch value.
- R11: req_ready is high only when the block is idle. A configuration count of 0 acts as 1, and the counts are sampled when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; low forgets the latch value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data (low byte used in byte mode) |
| cfg_ale_cycles | input | 4 | Latch pulse width in cycles |
| cfg_strobe_cycles | input | 4 | Strobe low time in cycles |
| cfg_hold_cycles | input | 4 | Hold time after the strobe in cycles |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Shared bus output value |
| ad_oe | output | 2 | Per-lane output enable, bit 1 = AD15-8 |
| ad_in | input | 16 | Shared bus input value |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The subtle case is skipping the latch phase when the latch value is unchanged, because the stored value is compared across modes. A byte-mode access whose addr[23:8] equals an earlier halfword access's addr[15:0] has to skip the latch phase. The stimulus builds that sequence on purpose. It also brings the same latch value back after a low pulse on enable, where a latch phase is required again. A bench-side external latch and memory model rebuilds each address from the pins, so an address or skip decision that goes wrong shows up as a wrong address or wrong read data.

// File: rtl/admux_pkg.sv
package admux_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALE,
      ST_RSETUP,
      ST_STROBE,
      ST_HOLD,
      ST_TURN
   } admux_state_e;

endpackage

// File: rtl/admux_ale_track.sv
module admux_ale_track #(
   parameter int AD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic [AD_W-1:0] cand,
   input  logic            load,
   output logic            need_ale
);

   logic [AD_W-1:0] stored_q;
   logic            valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= '0;
         valid_q  <= 1'b0;
      end else if (!enable) begin
         stored_q <= '0;
         valid_q  <= 1'b0;
      end else if (load) begin
         stored_q <= cand;
         valid_q  <= 1'b1;
      end
   end

   assign need_ale = !valid_q || (stored_q != cand);

endmodule

// File: rtl/admux_seq.sv
module admux_seq
   import admux_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             need_ale,
   input  logic             is_write,
   input  logic [CNT_W-1:0] cfg_ale,
   input  logic [CNT_W-1:0] cfg_strobe,
   input  logic [CNT_W-1:0] cfg_hold,
   output admux_state_e     state,
   output logic             done,
   output logic             capture
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] stb_last_q;
   logic [CNT_W-1:0] hold_last_q;
   logic             wr_q;

   function automatic logic [CNT_W-1:0] last_of(input logic [CNT_W-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt_q       <= '0;
         stb_last_q  <= '0;
         hold_last_q <= '0;
         wr_q        <= 1'b0;
         done        <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  wr_q        <= is_write;
                  stb_last_q  <= last_of(cfg_strobe);
                  hold_last_q <= last_of(cfg_hold);
                  if (need_ale) begin
                     state <= ST_ALE;
                     cnt_q <= last_of(cfg_ale);
                  end else if (is_write) begin
                     state <= ST_STROBE;
                     cnt_q <= last_of(cfg_strobe);
                  end else begin
                     state <= ST_RSETUP;
                  end
               end
            end
            ST_ALE: begin
               if (cnt_q == '0) begin
                  if (wr_q) begin
                     state <= ST_STROBE;
                     cnt_q <= stb_last_q;
                  end else begin
                     state <= ST_RSETUP;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_RSETUP: begin
               state <= ST_STROBE;
               cnt_q <= stb_last_q;
            end
            ST_STROBE: begin
               if (cnt_q == '0) begin
                  state <= ST_HOLD;
                  cnt_q <= hold_last_q;
                  done  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_q == '0) begin
                  state <= wr_q ? ST_IDLE : ST_TURN;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_TURN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign capture = (state == ST_STROBE) && (cnt_q == '0) && !wr_q;

endmodule

// File: rtl/admux_lane.sv
module admux_lane
   import admux_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter bit ADDR_LANE = 1'b0
) (
   input  admux_state_e      state,
   input  logic              wr,
   input  logic              wide,
   input  logic [LANE_W-1:0] lat_part,
   input  logic [LANE_W-1:0] addr_lo,
   input  logic [LANE_W-1:0] data_part,
   output logic [LANE_W-1:0] ad_o,
   output logic              oe
);

   logic carries_addr;
   assign carries_addr = ADDR_LANE && !wide;

   always_comb begin
      ad_o = '0;
      oe   = 1'b0;
      unique case (state)
         ST_ALE: begin
            ad_o = lat_part;
            oe   = 1'b1;
         end
         ST_RSETUP, ST_STROBE, ST_HOLD: begin
            if (carries_addr) begin
               ad_o = addr_lo;
               oe   = 1'b1;
            end else begin
               ad_o = wr ? data_part : '0;
               oe   = wr;
            end
         end
         default: begin
            ad_o = '0;
            oe   = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/admux_bus_master.sv
module admux_bus_master
   import admux_pkg::*;
#(
   parameter int AD_W  = 16,
   parameter int CNT_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic                     req_wide,
   input  logic [AD_W+AD_W/2-1:0]   req_addr,
   input  logic [AD_W-1:0]          req_wdata,
   input  logic [CNT_W-1:0]         cfg_ale_cycles,
   input  logic [CNT_W-1:0]         cfg_strobe_cycles,
   input  logic [CNT_W-1:0]         cfg_hold_cycles,
   output logic                     done,
   output logic [AD_W-1:0]          rdata,
   output logic [AD_W-1:0]          ad_out,
   output logic [1:0]               ad_oe,
   input  logic [AD_W-1:0]          ad_in,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n
);

   localparam int LANE_W = AD_W / 2;
   localparam int ADDR_W = AD_W + LANE_W;
   localparam int LANES  = 2;

   if (AD_W % 2 != 0 || AD_W < 4) begin : g_bad_width
      $error("admux_bus_master: AD_W must be even and at least 4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("admux_bus_master: CNT_W must be at least 1");
   end

   admux_state_e    state;
   logic            start;
   logic            need_ale;
   logic            capture;
   logic [AD_W-1:0] req_lat;

   logic [ADDR_W-1:0] addr_q;
   logic [AD_W-1:0]   wdata_q;
   logic [AD_W-1:0]   lat_q;
   logic              wr_q;
   logic              wide_q;

   assign req_ready = enable && (state == ST_IDLE);
   assign start     = req_valid && req_ready;
   assign req_lat   = req_wide ? req_addr[AD_W-1:0] : req_addr[ADDR_W-1:LANE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         lat_q   <= '0;
         wr_q    <= 1'b0;
         wide_q  <= 1'b0;
      end else if (start) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         lat_q   <= req_lat;
         wr_q    <= req_write;
         wide_q  <= req_wide;
      end
   end

   admux_ale_track #(.AD_W(AD_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .cand     (req_lat),
      .load     (start && need_ale),
      .need_ale (need_ale)
   );

   admux_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .need_ale   (need_ale),
      .is_write   (req_write),
      .cfg_ale    (cfg_ale_cycles),
      .cfg_strobe (cfg_strobe_cycles),
      .cfg_hold   (cfg_hold_cycles),
      .state      (state),
      .done       (done),
      .capture    (capture)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      admux_lane #(
         .LANE_W    (LANE_W),
         .ADDR_LANE (g == 1)
      ) u_lane (
         .state     (state),
         .wr        (wr_q),
         .wide      (wide_q),
         .lat_part  (lat_q[g*LANE_W +: LANE_W]),
         .addr_lo   (addr_q[LANE_W-1:0]),
         .data_part (wdata_q[g*LANE_W +: LANE_W]),
         .ad_o      (ad_out[g*LANE_W +: LANE_W]),
         .oe        (ad_oe[g])
      );
   end

   assign ale  = (state == ST_ALE);
   assign rd_n = !((state == ST_STROBE) && !wr_q);
   assign wr_n = !((state == ST_STROBE) && wr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         rdata <= wide_q ? ad_in : {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
      end
   end

endmodule

// File: rtl/admux_checker.sv
module admux_checker #(
   parameter int AD_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enable,
   input logic            req_ready,
   input logic            done,
   input logic [AD_W-1:0] ad_out,
   input logic [1:0]      ad_oe,
   input logic            ale,
   input logic            rd_n,
   input logic            wr_n
);

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> ($stable(ad_out) && ad_oe == 2'b11));

   assert_ale_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe == 2'b11 && rd_n && wr_n));

   assert_rd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe[0]);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(!rd_n || !wr_n));

   assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rd_n && wr_n && !ale && ad_oe == 2'b00));

   assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !req_ready);

endmodule

bind admux_bus_master admux_checker #(.AD_W(AD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .req_ready (req_ready),
   .done      (done),
   .ad_out    (ad_out),
   .ad_oe     (ad_oe),
   .ale       (ale),
   .rd_n      (rd_n),
   .wr_n      (wr_n)
);

// File: tb/sim_admux_bus_master.sv
module sim_admux_bus_master;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        wr;
      logic        wide;
      logic [23:0] addr;
      logic [15:0] wdata;
      logic        exp_ale;
      logic [3:0]  ale_w;
      logic [3:0]  stb_w;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_wide = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [3:0]  cfg_ale_cycles = 4'd1;
   logic [3:0]  cfg_strobe_cycles = 4'd1;
   logic [3:0]  cfg_hold_cycles = 4'd1;
   logic        done;
   logic [15:0] rdata;
   logic [15:0] ad_out;
   logic [1:0]  ad_oe;
   logic [15:0] ad_in;
   logic        ale;
   logic        rd_n;
   logic        wr_n;

   int n_tests = 0;
   int n_fail  = 0;

   item_t       sb_q[$];
   logic        model_valid = 1'b0;
   logic [15:0] model_lat = '0;
   logic [15:0] latch_q = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   admux_bus_master u0 (
      .clk               (clk),
      .rst_n             (rst_n),
      .enable            (enable),
      .req_valid         (req_valid),
      .req_ready         (req_ready),
      .req_write         (req_write),
      .req_wide          (req_wide),
      .req_addr          (req_addr),
      .req_wdata         (req_wdata),
      .cfg_ale_cycles    (cfg_ale_cycles),
      .cfg_strobe_cycles (cfg_strobe_cycles),
      .cfg_hold_cycles   (cfg_hold_cycles),
      .done              (done),
      .rdata             (rdata),
      .ad_out            (ad_out),
      .ad_oe             (ad_oe),
      .ad_in             (ad_in),
      .ale               (ale),
      .rd_n              (rd_n),
      .wr_n              (wr_n)
   );

   function automatic logic [15:0] memfn(input logic [23:0] a);
      return (a[15:0] * 16'd9) ^ {a[23:16], 8'h3C};
   endfunction

   function automatic int eff(input logic [3:0] n);
      return (n == 4'd0) ? 1 : int'(n);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // external memory model answering on the bus while the read strobe is low
   logic [15:0] mem_byte_word;
   always_comb begin
      mem_byte_word = memfn({latch_q, ad_out[15:8]});
      if (!rd_n) begin
         if (ad_oe[1]) ad_in = {8'hEE, mem_byte_word[7:0]};
         else          ad_in = memfn({8'h00, latch_q});
      end else begin
         ad_in = 16'hDEAD;
      end
   end

   // driver: issues a request and pushes the expected item
   task automatic access(input bit wr, input bit wide, input logic [23:0] addr,
                         input logic [15:0] wd, input logic [3:0] ca,
                         input logic [3:0] cs, input logic [3:0] ch);
      item_t it;
      logic [15:0] lat;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      lat = wide ? addr[15:0] : addr[23:8];
      it.wr      = wr;
      it.wide    = wide;
      it.addr    = wide ? {8'h00, addr[15:0]} : addr;
      it.wdata   = wd;
      it.exp_ale = !model_valid || (model_lat != lat);
      it.ale_w   = ca;
      it.stb_w   = cs;
      model_valid = 1'b1;
      model_lat   = lat;
      sb_q.push_back(it);
      req_valid = 1'b1;
      req_write = wr;
      req_wide  = wide;
      req_addr  = addr;
      req_wdata = wd;
      cfg_ale_cycles    = ca;
      cfg_strobe_cycles = cs;
      cfg_hold_cycles   = ch;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R11 busy ready", 32'(req_ready), 32'd0);
   endtask

   // monitor state
   int          ale_cnt = 0;
   int          stb_cnt = 0;
   bit          saw_ale = 0;
   logic [7:0]  stb_hi = '0;
   logic [15:0] wd_seen = '0;
   logic        prev_rd = 1'b1;
   logic [1:0]  prev_oe = '0;
   logic        done_prev = 1'b0;
   bit          pend_turn = 0;
   bit          zero_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         item_t e;
         logic [15:0] exp_rd;
         logic [15:0] tmp;
         if (ale) begin
            latch_q = ad_out;
            ale_cnt++;
            saw_ale = 1;
         end
         if (!rd_n || !wr_n) begin
            stb_cnt++;
            stb_hi  = ad_out[15:8];
            wd_seen = ad_out;
         end
         if (prev_rd && !rd_n && sb_q.size() > 0) begin
            chk(prev_oe == (sb_q[0].wide ? 2'b00 : 2'b10), "R7 release before rd_n",
                32'(prev_oe), sb_q[0].wide ? 32'd0 : 32'd2);
         end
         if (!rd_n) begin
            pend_turn = 1;
            zero_seen = 0;
         end else if (pend_turn && ad_oe == 2'b00) begin
            zero_seen = 1;
         end
         if (pend_turn && rd_n && ad_oe[0]) begin
            chk(zero_seen, "R9 turnaround", 32'(zero_seen), 32'd1);
            pend_turn = 0;
         end
         if (done) begin
            chk(!done_prev, "R8 single pulse", 32'(done_prev), 32'd0);
            if (sb_q.size() == 0) begin
               chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
            end else begin
               e = sb_q.pop_front();
               chk(saw_ale == e.exp_ale, "R3 ale decision", 32'(saw_ale), 32'(e.exp_ale));
               if (saw_ale)
                  chk(ale_cnt == eff(e.ale_w), "R2 ale width", 32'(ale_cnt), 32'(eff(e.ale_w)));
               if (e.wide)
                  chk(latch_q == e.addr[15:0], "R5 address", 32'(latch_q), 32'(e.addr[15:0]));
               else
                  chk({latch_q, stb_hi} == e.addr, "R4 address", 32'({latch_q, stb_hi}), 32'(e.addr));
               if (e.wr) begin
                  chk(stb_cnt == eff(e.stb_w), "R6 wr width", 32'(stb_cnt), 32'(eff(e.stb_w)));
                  if (e.wide)
                     chk(wd_seen == e.wdata, "R5 write data", 32'(wd_seen), 32'(e.wdata));
                  else
                     chk(wd_seen[7:0] == e.wdata[7:0], "R4 write byte", 32'(wd_seen[7:0]), 32'(e.wdata[7:0]));
                  chk(ad_oe == 2'b11 && ad_out == wd_seen, "R6 hold after wr_n",
                      32'({ad_oe, ad_out}), 32'({2'b11, wd_seen}));
               end else begin
                  chk(stb_cnt == eff(e.stb_w), "R7 rd width", 32'(stb_cnt), 32'(eff(e.stb_w)));
                  tmp = memfn(e.addr);
                  exp_rd = e.wide ? tmp : {8'h00, tmp[7:0]};
                  chk(rdata == exp_rd, "R7 R8 read data", 32'(rdata), 32'(exp_rd));
               end
            end
            ale_cnt = 0;
            stb_cnt = 0;
            saw_ale = 0;
         end
         done_prev = done;
         prev_rd   = rd_n;
         prev_oe   = ad_oe;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (sb_q.size() != 0 || !req_ready) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rd_n && wr_n && !ale && ad_oe == 2'b00 && !done, "R1 outputs in reset",
          32'({rd_n, wr_n, ale, ad_oe, done}), 32'b110000);
      enable = 1'b1;
      rst_n  = 1'b1;
      @(negedge clk);
      chk(rd_n && wr_n && !ale && ad_oe == 2'b00 && !done && rdata == 16'h0, "R1 after reset",
          32'({rd_n, wr_n, ale, ad_oe, done}), 32'b110000);
      chk(req_ready, "R1 ready", 32'(req_ready), 32'd1);

      // byte mode, first access forces latch phase
      access(1'b1, 1'b0, 24'h123456, 16'h00AB, 4'd2, 4'd3, 4'd2);
      // same upper bits: no latch phase
      access(1'b0, 1'b0, 24'h123457, 16'h0000, 4'd2, 4'd3, 4'd2);
      // changed upper bits
      access(1'b1, 1'b0, 24'h123500, 16'h00C4, 4'd1, 4'd2, 4'd1);
      // halfword mode read, new latch value
      access(1'b0, 1'b1, 24'h003500, 16'h0000, 4'd3, 4'd2, 4'd1);
      // halfword write, same latch value
      access(1'b1, 1'b1, 24'h003500, 16'hBEEF, 4'd3, 4'd4, 4'd3);
      // zero counts behave as one
      access(1'b0, 1'b1, 24'h003500, 16'h0000, 4'd0, 4'd0, 4'd0);
      // byte mode whose latch value matches the halfword latch value
      access(1'b1, 1'b0, 24'h350022, 16'h0077, 4'd0, 4'd0, 4'd0);
      // back-to-back byte reads, read then write
      access(1'b0, 1'b0, 24'h350023, 16'h0000, 4'd1, 4'd5, 4'd1);
      access(1'b0, 1'b0, 24'hA10001, 16'h0000, 4'd2, 4'd1, 4'd3);
      access(1'b1, 1'b0, 24'hA10002, 16'h0099, 4'd1, 4'd1, 4'd1);
      wait_idle();

      // disable: requests ignored and latch value forgotten
      enable = 1'b0;
      model_valid = 1'b0;
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = 24'hA10003;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(!req_ready && rd_n && wr_n && !ale && !done, "R10 disabled idle",
             32'({req_ready, rd_n, wr_n, ale, done}), 32'b01100);
      end
      req_valid = 1'b0;
      enable = 1'b1;
      access(1'b1, 1'b0, 24'hA10003, 16'h0055, 4'd2, 4'd2, 4'd1);
      access(1'b0, 1'b1, 24'h00A100, 16'h0000, 4'd1, 4'd3, 4'd2);
      access(1'b0, 1'b1, 24'h00A100, 16'h0000, 4'd1, 4'd2, 4'd1);
      wait_idle();
      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R8 all done seen", 32'(sb_q.size()), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule